// File: doc/BRIEF.md
# Programmable SPI Serial Clock Generator

This block derives the serial clock (SCK) for an SPI flash master from a faster input clock. It takes a 32-bit clock configuration word as a plain input. Two 6-bit count fields in that word set the length of each SCK period and the length of its high phase. A third 6-bit field holds a plain divide ratio. When the period field is zero, the block uses the divide ratio and picks a near-even high/low split by itself. The fastest clock is the input clock divided by 2, and the slowest is the input clock divided by 64.

The block also drives two one-cycle strobes for a shift engine. A sample strobe marks each rising SCK edge, and a launch strobe marks each falling SCK edge. While the enable input is low, SCK rests low. When enable drops, SCK finishes the period it is in before it goes idle, so no shortened pulse appears. A new configuration word is taken only when a period begins. One bit of the word names the clock source. The block only registers that bit and brings it out as a status bit.

Top module: `sckgen_top`

## Requirements
- R1: The period field sits at bits 5:0 of the word. When it holds a nonzero value t, and enable stays high, SCK repeats every t+1 input cycles.
- R2: The high-count field sits at bits 11:6. Given its value h, with h < t, each period begins with h+1 cycles of SCK high and ends with t-h cycles of SCK low.
- R3: If the period field is zero, the divide field (bits 17:12) sets the period. Its value n is used as t, except that 0 is treated as 1. The high count then becomes ((t+1)/2)-1, and the high-count field is ignored.
- R4: If the period field is nonzero and h >= t, the high count is cut to t-1, so every period has at least one low cycle.
- R5: When the period field is nonzero, the divide field has no effect on SCK or on the strobes.
- R6: sample_o is high for exactly the first high cycle of each period. launch_o is high for exactly the first low cycle of each period. The two strobes are never high in the same cycle.
- R7: While the block is idle, SCK and both strobes stay low. If enable is seen low at the last cycle of a period, the block goes idle straight after that cycle.
- R8: Suppose enable is sampled high by a clock edge while the block is idle. SCK and sample_o then go high in the cycle that follows that edge.
- R9: A change to the word in the middle of a period does not alter that period. The new values apply from the next period onward.
- R10: src_sel_o shows bit 31 of the word one input cycle later, and that bit does not change the SCK waveform.
- R11: During reset, sck_o, launch_o, sample_o and src_sel_o are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Fast input clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Run request; SCK toggles while high |
| cfg_word_i | input | 32 | Clock configuration word |
| sck_o | output | 1 | Serial clock, low when idle |
| launch_o | output | 1 | One-cycle strobe on each falling SCK edge |
| sample_o | output | 1 | One-cycle strobe on each rising SCK edge |
| src_sel_o | output | 1 | Registered copy of the clock-source bit |

## Verification
The assertions take two things for granted. First, enable and the configuration word change only between clock edges and are never unknown after reset. Second, reset is held long enough to clear the phase counter before enable rises. The bench drives every input on the falling edge of the clock. It keeps each word well formed, with the reserved bits at zero, and it changes the word in mid-period only in the test written for that purpose. Enable is dropped only after a pattern has run for a whole number of cycles, so each stop still lets the current period finish before the idle checks start.

// File: rtl/sckgen_pkg.sv
package sckgen_pkg;

  localparam int SCK_CNT_W = 6;

  typedef logic [SCK_CNT_W-1:0] cnt_t;

  // terminal count of one period (period lasts term+1 input cycles)
  function automatic cnt_t period_term(input cnt_t lo_f, input cnt_t div_f);
    if (lo_f != '0)       return lo_f;
    else if (div_f != '0) return div_f;
    else                  return cnt_t'(1);
  endfunction

  // last counter value at which SCK is still high
  function automatic cnt_t high_term(input cnt_t lo_f, input cnt_t hi_f,
                                     input cnt_t term);
    logic [SCK_CNT_W:0] half;
    half = ({1'b0, term} + 1'b1) >> 1;
    if (lo_f == '0)        return cnt_t'(half - 1'b1);
    else if (hi_f >= term) return cnt_t'(term - 1'b1);
    else                   return hi_f;
  endfunction

endpackage

// File: rtl/sckgen_cfg_latch.sv
module sckgen_cfg_latch
  import sckgen_pkg::*;
#(
  parameter int WORD_W  = 32,
  parameter int LO_LSB  = 0,
  parameter int HI_LSB  = 6,
  parameter int DIV_LSB = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [WORD_W-1:0] word_i,
  output cnt_t              term_o,
  output cnt_t              high_o
);
  cnt_t lo_f, hi_f, div_f, term_n;
  cnt_t term_q, high_q;

  assign lo_f   = word_i[LO_LSB  +: SCK_CNT_W];
  assign hi_f   = word_i[HI_LSB  +: SCK_CNT_W];
  assign div_f  = word_i[DIV_LSB +: SCK_CNT_W];
  assign term_n = period_term(lo_f, div_f);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      term_q <= cnt_t'(1);
      high_q <= '0;
    end else if (load_i) begin
      term_q <= term_n;
      high_q <= high_term(lo_f, hi_f, term_n);
    end
  end

  assign term_o = term_q;
  assign high_o = high_q;
endmodule

// File: rtl/sckgen_phase_ctr.sv
module sckgen_phase_ctr
  import sckgen_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  cnt_t term_i,
  output logic run_o,
  output cnt_t cnt_o,
  output logic load_o
);
  logic run_q;
  cnt_t cnt_q;
  logic start_w, wrap_w;

  assign start_w = !run_q && en_i;
  assign wrap_w  = run_q && (cnt_q == term_i);
  assign load_o  = start_w || (wrap_w && en_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (start_w) begin
      run_q <= 1'b1;
      cnt_q <= '0;
    end else if (wrap_w) begin
      run_q <= en_i;
      cnt_q <= '0;
    end else if (run_q) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign run_o = run_q;
  assign cnt_o = cnt_q;
endmodule

// File: rtl/sckgen_edge_dec.sv
module sckgen_edge_dec
  import sckgen_pkg::*;
(
  input  logic run_i,
  input  cnt_t cnt_i,
  input  cnt_t high_i,
  output logic sck_o,
  output logic rise_o,
  output logic fall_o
);
  assign sck_o  = run_i && (cnt_i <= high_i);
  assign rise_o = run_i && (cnt_i == '0);
  assign fall_o = run_i && (cnt_i == cnt_t'(high_i + 1'b1));
endmodule

// File: rtl/sckgen_top.sv
module sckgen_top
  import sckgen_pkg::*;
#(
  parameter int WORD_W  = 32,
  parameter int LO_LSB  = 0,
  parameter int HI_LSB  = 6,
  parameter int DIV_LSB = 12,
  parameter int SRC_BIT = 31
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [WORD_W-1:0] cfg_word_i,
  output logic              sck_o,
  output logic              launch_o,
  output logic              sample_o,
  output logic              src_sel_o
);
  // named internal events, visible to the bound checker
  logic run_w;
  cnt_t cnt_w;
  cnt_t term_w;
  cnt_t high_w;
  logic load_w;
  logic src_q;

  sckgen_phase_ctr u_ctr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .term_i (term_w),
    .run_o  (run_w),
    .cnt_o  (cnt_w),
    .load_o (load_w)
  );

  sckgen_cfg_latch #(
    .WORD_W (WORD_W),
    .LO_LSB (LO_LSB),
    .HI_LSB (HI_LSB),
    .DIV_LSB(DIV_LSB)
  ) u_cfg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load_w),
    .word_i (cfg_word_i),
    .term_o (term_w),
    .high_o (high_w)
  );

  sckgen_edge_dec u_dec (
    .run_i  (run_w),
    .cnt_i  (cnt_w),
    .high_i (high_w),
    .sck_o  (sck_o),
    .rise_o (sample_o),
    .fall_o (launch_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) src_q <= 1'b0;
    else         src_q <= cfg_word_i[SRC_BIT];
  end

  assign src_sel_o = src_q;
endmodule

// File: rtl/sckgen_checker.sv
module sckgen_checker
  import sckgen_pkg::*;
(
  input logic clk_i,
  input logic rst_ni,
  input logic en_i,
  input logic sck_o,
  input logic launch_o,
  input logic sample_o,
  input logic run_w,
  input cnt_t cnt_w,
  input cnt_t term_w,
  input cnt_t high_w
);
  assert_idle_low_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_w |-> (!sck_o && !launch_o && !sample_o));

  assert_stop_at_end_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_w && cnt_w == term_w && !en_i) |=> !run_w);

  assert_rise_strobe_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sck_o) |-> sample_o);

  assert_fall_strobe_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sck_o) |-> launch_o);

  assert_strobe_excl_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({launch_o, sample_o}));

  assert_cnt_bound_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_w |-> (cnt_w <= term_w));

  assert_low_phase_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_w |-> (high_w < term_w));

  assert_cfg_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_w && cnt_w != '0) |-> ($stable(term_w) && $stable(high_w)));
endmodule

bind sckgen_top sckgen_checker chk_i (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .en_i     (en_i),
  .sck_o    (sck_o),
  .launch_o (launch_o),
  .sample_o (sample_o),
  .run_w    (run_w),
  .cnt_w    (cnt_w),
  .term_w   (term_w),
  .high_w   (high_w)
);

// File: tb/sckgen_top_tb_top.sv
module sckgen_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic [31:0] cfg = '0;
  logic        sck, launch, sample, src_sel;
  int          n_chk = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  sckgen_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .cfg_word_i(cfg),
    .sck_o(sck), .launch_o(launch), .sample_o(sample), .src_sel_o(src_sel)
  );

  function automatic logic [31:0] mk(input bit src, input int dv, input int hi, input int lo);
    return {src, 13'd0, 6'(dv), 6'(hi), 6'(lo)};
  endfunction

  // expected period length and high-phase length, taken from the requirements
  function automatic int per_len(input logic [31:0] w);
    int lo = int'(w[5:0]);
    int dv = int'(w[17:12]);
    if (lo > 0) return lo + 1;
    return (dv > 0 ? dv : 1) + 1;
  endfunction

  function automatic int high_len(input logic [31:0] w);
    int lo = int'(w[5:0]);
    int hi = int'(w[11:6]);
    int p  = per_len(w);
    if (lo == 0) return p / 2;
    return (hi < lo) ? hi + 1 : lo;
  endfunction

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  // check one cycle at phase index ph of a period of length p with hl high cycles
  task automatic chk_phase(input string req, input int ph, input int p, input int hl);
    int k = ph % p;
    chk({req, " sck"},    sck,    k < hl);
    chk({req, " sample"}, sample, k == 0);
    chk({req, " launch"}, launch, k == hl);
  endtask

  task automatic chk_idle(input string req, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk({req, " idle sck"}, sck, 1'b0);
      chk({req, " idle strobes"}, launch | sample, 1'b0);
    end
  endtask

  // R1 R2 R6 R8 R7: run a word for ncyc cycles, drop enable, finish the period, idle
  task automatic run_pattern(input string req, input logic [31:0] w, input int ncyc);
    int p = per_len(w);
    int hl = high_len(w);
    int stop;
    @(negedge clk);
    cfg = w;
    en = 1'b1;
    chk({req, " R8 before start"}, sck, 1'b0);
    for (int j = 0; j < ncyc; j++) begin
      @(negedge clk);
      chk_phase(req, j, p, hl);
    end
    en = 1'b0;
    stop = ((ncyc - 1) / p + 1) * p;
    for (int j = ncyc; j < stop; j++) begin
      @(negedge clk);
      chk_phase({req, " R7 tail"}, j, p, hl);
    end
    chk_idle({req, " R7"}, 3);
  endtask

  task automatic t_reset();
    chk("R11 sck", sck, 1'b0);
    chk("R11 launch", launch, 1'b0);
    chk("R11 sample", sample, 1'b0);
    chk("R11 src", src_sel, 1'b0);
  endtask

  // R9: word changed mid-period applies from the next period
  task automatic t_cfg_change();
    logic [31:0] wa = mk(0, 0, 1, 3);
    logic [31:0] wb = mk(0, 0, 2, 5);
    @(negedge clk);
    cfg = wa;
    en = 1'b1;
    for (int j = 0; j < 6; j++) begin
      @(negedge clk);
      chk_phase("R9 old", j, per_len(wa), high_len(wa));
    end
    cfg = wb;
    for (int j = 6; j < 8; j++) begin
      @(negedge clk);
      chk_phase("R9 old kept", j, per_len(wa), high_len(wa));
    end
    for (int j = 0; j < 12; j++) begin
      @(negedge clk);
      chk_phase("R9 new", j, per_len(wb), high_len(wb));
    end
    en = 1'b0;
    chk_idle("R9", 3);
  endtask

  // R10: source bit shows on src_sel_o one cycle later
  task automatic t_src();
    @(negedge clk);
    cfg = mk(1, 0, 1, 3);
    chk("R10 not yet", src_sel, 1'b0);
    @(negedge clk);
    chk("R10 set", src_sel, 1'b1);
    chk("R10 sck idle", sck, 1'b0);
    cfg = '0;
    @(negedge clk);
    chk("R10 clear", src_sel, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    chk_idle("R7 after reset", 2);
    run_pattern("R1 R2 R6 t3h1", mk(0, 0, 1, 3), 16);
    run_pattern("R1 R2 t5h0",    mk(0, 0, 0, 5), 13);
    run_pattern("R1 R2 t6h4",    mk(0, 0, 4, 6), 14);
    run_pattern("R1 t1h0",       mk(0, 0, 0, 1), 7);
    run_pattern("R4 clamp",      mk(0, 0, 7, 2), 9);
    run_pattern("R4 clamp eq",   mk(0, 0, 3, 3), 8);
    run_pattern("R3 ratio 4",    mk(0, 4, 9, 0), 10);
    run_pattern("R3 ratio 0",    mk(0, 0, 5, 0), 6);
    run_pattern("R3 ratio 63",   mk(0, 63, 0, 0), 130);
    run_pattern("R5 div ignored", mk(0, 9, 2, 4), 10);
    run_pattern("R10 src no effect", mk(1, 0, 2, 4), 10);
    t_cfg_change();
    t_src();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule